// File: doc/BRIEF.md
# Counter Bit-Transition Event Generator

This block watches one chosen bit of a free-running 64-bit count. Each time that bit makes the chosen transition, it emits a one-cycle event pulse. The transition is either low-to-high or high-to-low. Instead of comparing the bit against its previous value, the block plans ahead. It computes the count value at which the next matching edge happens and holds that value as a target. It fires once the count reaches or passes the target, then computes the next target from the count at that moment.

The count input is whatever view of time the owner wants to track, for example a physical count or a count with an offset already applied. The enable, bit select, direction and re-arm inputs are plain level controls. The count is a continuously valid level, not a stream, so the block has no valid/ready handshake: it never applies back-pressure and it never drops a sample. Delivering the event to a consumer is left to the surrounding logic.

The bit select and direction are taken as new whenever they differ from the values used for the last target computation. A one-cycle re-arm request forces a fresh computation from the current count.

Top module: `cbt_event_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `evt_o` is 0 and `target_o` is 0.
- R2: Target computation for the low-to-high direction (`dir_i`=1): when the selected bit of the count is 0, the new target is the count with all bits below `sel_i` cleared, plus 2^`sel_i`.
- R3: When the selected bit already equals the direction value, 2^(`sel_i`+1) is added instead of 2^`sel_i`, so the target is the next matching edge and not the current level.
- R4: With `dir_i`=0 the high-to-low edge is tracked, using the same rule with the roles of 0 and 1 swapped.
- R5: When the block is enabled, armed and not reloading, a count greater than or equal to the target raises `evt_o` for exactly one cycle, starting one clock after that count is presented. At the same edge a new target is computed from that count.
- R6: A count that jumps past the target in one step fires exactly once. It does not fire again on later cycles while the count stays below the new target.
- R7: While `enable_i` is 0, `evt_o` stays 0 and `target_o` holds its value.
- R8: A new target is computed from the current count on the first enabled cycle after a disabled one, and on any enabled cycle in which `sel_i` or `dir_i` differs from the values last used. Such a reload never fires an event in the same cycle.
- R9: A `rearm_i` pulse while enabled reloads the target from the current count, without an event, even if the count already passes the old target.
- R10: If the computed target does not fit in 64 bits (`sel_i`=63 with the bit already at the direction value), `target_o` shows the low 64 bits and no event is produced until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Count value being watched |
| enable_i | input | 1 | Enables event generation |
| sel_i | input | 6 | Index of the watched bit |
| dir_i | input | 1 | 1 selects the low-to-high edge, 0 selects the high-to-low edge |
| rearm_i | input | 1 | One-cycle request to recompute the target from the current count |
| evt_o | output | 1 | One-cycle event pulse |
| target_o | output | 64 | Count value at which the next event is due |

## Verification
The hardest state to reach is a target beyond the 64-bit range. It needs bit 63 selected and that bit already at the direction value. The bench gets there in two ways. First, it fires on a count of exactly 2^63, which makes the post-fire computation overflow. Then it drives the all-ones count to show that nothing fires. It also pairs a large forward jump with a re-enable while the count is far past the held target. This shows that the reload takes priority over a stale comparison.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_dir_e;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_FIRE = 2'd2,
    ACT_HOLD = 2'd3
  } cbt_act_e;

endpackage

// File: rtl/cbt_target_calc.sv
module cbt_target_calc #(
  parameter int CNT_W = 64,
  parameter int SEL_W = $clog2(CNT_W)
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             dir_i,
  output logic [CNT_W-1:0] target_o,
  output logic             beyond_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] keep_mask;
  logic [CNT_W-1:0] base;
  logic [SUM_W-1:0] unit;
  logic [SUM_W-1:0] stride;
  logic [SUM_W-1:0] sum;
  logic             cur_bit;

  // The mask keeps the selected bit and everything above it.
  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign keep_mask[g] = (SEL_W'(g) >= sel_i);
  end

  always_comb begin
    cur_bit  = count_i[sel_i];
    base     = count_i & keep_mask;
    unit     = SUM_W'(1) << sel_i;
    // When the bit already sits at the wanted level, skip one whole half-period.
    stride   = (cur_bit == dir_i) ? (unit << 1) : unit;
    sum      = {1'b0, base} + stride;
    target_o = sum[CNT_W-1:0];
    beyond_o = sum[CNT_W];
  end

endmodule

// File: rtl/cbt_reach_cmp.sv
module cbt_reach_cmp #(
  parameter int CNT_W = 64
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic             beyond_i,
  output logic             reached_o
);
  // A target past the count range can never be reached.
  assign reached_o = !beyond_i && (count_i >= target_i);
endmodule

// File: rtl/cbt_cfg_track.sv
module cbt_cfg_track #(
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             dir_i,
  input  logic             rearm_i,
  output logic             reload_o,
  output logic [SEL_W-1:0] sel_q_o
);
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
      dir_q <= 1'b0;
    end else begin
      en_q <= enable_i;
      if (enable_i) begin
        sel_q <= sel_i;
        dir_q <= dir_i;
      end
    end
  end

  assign reload_o = enable_i && (!en_q || rearm_i || (sel_i != sel_q) || (dir_i != dir_q));
  assign sel_q_o  = sel_q;

  AST_CFG_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i |=> (sel_q == $past(sel_i))); // R8

endmodule

// File: rtl/cbt_event_gen.sv
module cbt_event_gen
  import cbt_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int SEL_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             enable_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             dir_i,
  input  logic             rearm_i,
  output logic             evt_o,
  output logic [CNT_W-1:0] target_o
);
  logic [CNT_W-1:0] next_tgt;
  logic             next_beyond;
  logic [CNT_W-1:0] target_q;
  logic             beyond_q;
  logic             armed_q;
  logic             evt_q;
  logic             reached;
  logic             reload;
  logic [SEL_W-1:0] sel_q;
  cbt_act_e         act;

  cbt_target_calc #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_calc (
    .count_i (count_i),
    .sel_i   (sel_i),
    .dir_i   (dir_i),
    .target_o(next_tgt),
    .beyond_o(next_beyond)
  );

  cbt_reach_cmp #(.CNT_W(CNT_W)) u_cmp (
    .count_i  (count_i),
    .target_i (target_q),
    .beyond_i (beyond_q),
    .reached_o(reached)
  );

  cbt_cfg_track #(.SEL_W(SEL_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable_i(enable_i),
    .sel_i   (sel_i),
    .dir_i   (dir_i),
    .rearm_i (rearm_i),
    .reload_o(reload),
    .sel_q_o (sel_q)
  );

  // Reload has priority over firing.
  always_comb begin
    if (!enable_i)                act = ACT_HOLD;
    else if (reload)              act = ACT_LOAD;
    else if (armed_q && reached)  act = ACT_FIRE;
    else                          act = ACT_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      beyond_q <= 1'b0;
      armed_q  <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      unique case (act)
        ACT_LOAD, ACT_FIRE: begin
          target_q <= next_tgt;
          beyond_q <= next_beyond;
          armed_q  <= 1'b1;
          evt_q    <= (act == ACT_FIRE);
        end
        ACT_HOLD: begin
          armed_q <= 1'b0;
          evt_q   <= 1'b0;
        end
        default: evt_q <= 1'b0;
      endcase
    end
  end

  assign evt_o    = evt_q;
  assign target_o = target_q;

  logic [CNT_W-1:0] low_mask;
  assign low_mask = ~({CNT_W{1'b1}} << sel_q);

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !evt_o); // R7
  AST_TGT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (target_o == $past(target_o))); // R7
  AST_FIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (!$past(beyond_q) && ($past(count_i) >= $past(target_o)))); // R5
  AST_TGT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && (reload || reached)) |=> (beyond_q || (target_o > $past(count_i)))); // R6
  AST_TGT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> ((target_o & low_mask) == '0)); // R2
  AST_NO_FIRE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !evt_o); // R9
  AST_BEYOND_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (beyond_q && !reload) |=> !evt_o); // R10

endmodule

// File: tb/cbt_event_gen_tb.sv
`timescale 1ns/1ps
module cbt_event_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count_i = '0;
  logic        enable_i = 1'b0;
  logic [5:0]  sel_i = '0;
  logic        dir_i = 1'b0;
  logic        rearm_i = 1'b0;
  logic        evt_o;
  logic [63:0] target_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  cbt_event_gen u_dut (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .enable_i(enable_i),
    .sel_i(sel_i), .dir_i(dir_i), .rearm_i(rearm_i),
    .evt_o(evt_o), .target_o(target_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycle %0d expected < 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // Next-edge value per the target rule; result bit 64 marks out-of-range.
  function automatic logic [64:0] ref_tgt(input logic [63:0] c, input int s, input logic d);
    logic [64:0] b;
    b = {1'b0, (c >> s) << s};
    if (c[s] == d) return b + (65'd1 << (s + 1));
    return b + (65'd1 << s);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 evt in reset", {63'd0, evt_o}, 64'd0);
    chk("R1 target in reset", target_o, 64'd0);
    rst_n = 1'b1;
    step();
    chk("R1 evt after reset", {63'd0, evt_o}, 64'd0);
    chk("R1 target after reset", target_o, 64'd0);
  endtask

  task automatic t_rise_and_fire();
    enable_i = 1; sel_i = 4; dir_i = 1; count_i = 64'h100;
    step();
    chk("R2 rising target", target_o, ref_tgt(64'h100, 4, 1'b1) & 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 literal", target_o, 64'h110);
    count_i = 64'h10F; step();
    chk("R5 no evt below target", {63'd0, evt_o}, 64'd0);
    count_i = 64'h110; step();
    chk("R5 evt at target", {63'd0, evt_o}, 64'd1);
    chk("R3 rearmed target skips level", target_o, 64'h130);
    step();
    chk("R5 pulse is one cycle", {63'd0, evt_o}, 64'd0);
  endtask

  task automatic t_fall();
    dir_i = 0; step();
    chk("R4 falling target", target_o, 64'h120);
    dir_i = 1; sel_i = 0; step();
    dir_i = 0; count_i = 64'h5; step();
    chk("R4 falling bit0", target_o, 64'h6);
    count_i = 64'h6; step();
    chk("R4 evt on fall", {63'd0, evt_o}, 64'd1);
    chk("R3 falling skip", target_o, 64'h8);
  endtask

  task automatic t_sel_change_and_jump();
    dir_i = 1; sel_i = 8; count_i = 64'h110; step();
    chk("R8 sel change reload", target_o, 64'h300);
    chk("R8 no evt on reload", {63'd0, evt_o}, 64'd0);
    count_i = 64'h1000; step();
    chk("R6 jump fires", {63'd0, evt_o}, 64'd1);
    chk("R6 target after jump", target_o, 64'h1100);
    step();
    chk("R6 no second fire", {63'd0, evt_o}, 64'd0);
    step();
    chk("R6 still quiet", {63'd0, evt_o}, 64'd0);
  endtask

  task automatic t_disable();
    enable_i = 0; count_i = 64'h5000;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7 no evt disabled", {63'd0, evt_o}, 64'd0);
      chk("R7 target held", target_o, 64'h1100);
    end
    enable_i = 1; step();
    chk("R8 reenable reload", target_o, 64'h5100);
    chk("R8 reenable no evt", {63'd0, evt_o}, 64'd0);
  endtask

  task automatic t_rearm();
    count_i = 64'h5180; rearm_i = 1; step();
    rearm_i = 0;
    chk("R9 rearm target", target_o, 64'h5300);
    chk("R9 rearm no evt", {63'd0, evt_o}, 64'd0);
    step();
    chk("R9 quiet after", {63'd0, evt_o}, 64'd0);
  endtask

  task automatic t_beyond();
    sel_i = 63; dir_i = 1; count_i = 64'h0; step();
    chk("R2 top bit target", target_o, 64'h8000_0000_0000_0000);
    count_i = 64'h8000_0000_0000_0000; step();
    chk("R10 fire at top", {63'd0, evt_o}, 64'd1);
    chk("R10 wrapped target", target_o, 64'h8000_0000_0000_0000);
    count_i = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R10 no evt beyond range", {63'd0, evt_o}, 64'd0);
    end
  endtask

  initial begin
    #1;
    t_reset();
    t_rise_and_fire();
    t_fall();
    t_sel_change_and_jump();
    t_disable();
    t_rearm();
    t_beyond();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule